// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block checks every CPU memory access against a small set of programmable address regions and returns a permit or fault verdict in the same cycle as the request. Each region has an inclusive lower bound and an inclusive upper bound, both at 32-byte granularity. It also has an enable bit, a read-only flag and a privileged-only flag. Where regions overlap, the region with the highest index decides the access. An access that hits no enabled region is allowed only for privileged code, and only when the bank's background bit is set.

Two independent register banks hold the configuration, one for the Secure state and one for the Non-secure state. The security state of an access picks the bank that judges it. The security state of a configuration access picks the bank that it reads or writes. When a bank's global enable is clear, every access in that security state is permitted. Configuration accesses from unprivileged code are refused: they change nothing and read back zero, so unprivileged software cannot bypass the protection.

The unit has no sequencing of its own. Configuration writes take effect at the clock edge. Access checks are purely combinational over the stored state.

Top module: `rgn_mpu`

## Requirements
- R1: After reset, every configuration word of both banks reads as zero, so both banks are disabled with all regions off.
- R2: While the global enable of the selected bank is clear, every valid access is permitted and no fault is raised.
- R3: A region matches when it is enabled and `acc_addr[31:5]` lies between its lower and upper bound fields, both inclusive. Address bits 4:0 play no part, so an upper bound word of 0x10E0 covers addresses up to 0x10FF. A disabled region never matches.
- R4: A matching region whose privileged-only flag is set faults unprivileged accesses and permits privileged ones.
- R5: A matching region whose read-only flag is set faults writes at both privilege levels and permits reads.
- R6: When several enabled regions match, the one with the highest index alone decides the result.
- R7: An access that matches no enabled region is permitted when `acc_priv` is 1 and the bank's background bit is 1. In every other case it faults.
- R8: `acc_secure`=1 selects the Secure bank and 0 the Non-secure bank. `cfg_secure` selects the bank for configuration accesses in the same way. Writing one bank leaves the other bank's contents and verdicts unchanged.
- R9: A configuration access with `cfg_priv`=0 raises `cfg_err` in the same cycle. Its write is discarded and `cfg_rdata` reads zero.
- R10: The configuration words are laid out as follows:
  - Word 0 is the control word: bit 0 is the global enable and bit 1 is the background bit.
  - Word 8+n is the lower word of region n: bits 31:5 hold the lower bound and bit 0 is the region enable.
  - Word 16+n is the upper word of region n: bits 31:5 hold the upper bound, bit 0 is read-only and bit 1 is privileged-only.
  - Unlisted bits read zero. Unmapped words read zero and ignore writes.
- R11: `acc_permit` and `acc_fault` are combinational in the request cycle and never both high. Both are low when `acc_valid` is low. An access that arrives in the same cycle as a configuration write is judged by the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Privilege of the configuration access |
| cfg_secure | input | 1 | Bank selected for the configuration access (1 = Secure) |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| cfg_err | output | 1 | Configuration access refused |
| acc_valid | input | 1 | Access check request |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged access |
| acc_secure | input | 1 | Security state of the access (1 = Secure) |
| acc_permit | output | 1 | Access allowed |
| acc_fault | output | 1 | Access refused |

## Verification
A configuration write and an access check can fall in the same cycle. When that happens, the check must use the register contents from before the write. The bench provokes this by putting a write that clears the Non-secure control word together with an unprivileged, unmatched Non-secure access. It samples the verdict before the clock edge and expects a fault. It then holds the same access after the edge and expects a permit. The same pairing is used to show that an unprivileged write in the same cycle changes nothing.

// File: rtl/rgn_mpu_pkg.sv
package rgn_mpu_pkg;
    localparam int ADDR_W    = 32;
    localparam int GRAN_LOG2 = 5;
    localparam int BLK_W     = ADDR_W - GRAN_LOG2;
    localparam int CFG_AW    = 5;
    localparam int CTRL_IDX  = 0;
    localparam int LOWER_IDX = 8;
    localparam int UPPER_IDX = 16;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic en;
        logic ro;
        logic po;
        blk_t lo;
        blk_t hi;
    } region_t;

    typedef struct packed {
        logic en;
        logic bg;
    } bank_ctrl_t;
endpackage

// File: rtl/rgn_mpu_match.sv
module rgn_mpu_match
    import rgn_mpu_pkg::*;
(
    input  region_t rgn,
    input  blk_t    blk,
    output logic    hit
);
    assign hit = rgn.en && (blk >= rgn.lo) && (blk <= rgn.hi);
endmodule

// File: rtl/rgn_mpu_prio.sv
module rgn_mpu_prio #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  hit,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Later (higher) indices override earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rgn_mpu_bank.sv
module rgn_mpu_bank
    import rgn_mpu_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] cfg_idx,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_data,
    input  blk_t              blk,
    output logic              ctl_en,
    output logic              ctl_bg,
    output logic              any_hit,
    output region_t           win
);
    bank_ctrl_t      ctrl;
    region_t         rg [N];
    logic [N-1:0]    hit;
    logic [IW-1:0]   win_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            for (int r = 0; r < N; r++) rg[r] <= '0;
        end else if (wr_en) begin
            if (cfg_idx == CFG_AW'(CTRL_IDX)) begin
                ctrl.en <= wr_data[0];
                ctrl.bg <= wr_data[1];
            end
            for (int r = 0; r < N; r++) begin
                if (cfg_idx == CFG_AW'(LOWER_IDX + r)) begin
                    rg[r].lo <= wr_data[ADDR_W-1:GRAN_LOG2];
                    rg[r].en <= wr_data[0];
                end
                if (cfg_idx == CFG_AW'(UPPER_IDX + r)) begin
                    rg[r].hi <= wr_data[ADDR_W-1:GRAN_LOG2];
                    rg[r].ro <= wr_data[0];
                    rg[r].po <= wr_data[1];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (cfg_idx == CFG_AW'(CTRL_IDX))
            rd_data = {{(ADDR_W-2){1'b0}}, ctrl.bg, ctrl.en};
        for (int r = 0; r < N; r++) begin
            if (cfg_idx == CFG_AW'(LOWER_IDX + r))
                rd_data = {rg[r].lo, {(GRAN_LOG2-1){1'b0}}, rg[r].en};
            if (cfg_idx == CFG_AW'(UPPER_IDX + r))
                rd_data = {rg[r].hi, {(GRAN_LOG2-2){1'b0}}, rg[r].po, rg[r].ro};
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_match
        rgn_mpu_match u_match (
            .rgn (rg[g]),
            .blk (blk),
            .hit (hit[g])
        );
    end

    rgn_mpu_prio #(.N(N), .IW(IW)) u_prio (
        .hit (hit),
        .any (any_hit),
        .idx (win_idx)
    );

    assign win    = rg[win_idx];
    assign ctl_en = ctrl.en;
    assign ctl_bg = ctrl.bg;

    // Bank contents move only on a granted write to this bank
    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));
    assert_win_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> hit[win_idx]);
endmodule

// File: rtl/rgn_mpu.sv
module rgn_mpu
    import rgn_mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic              cfg_priv,
    input  logic              cfg_secure,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              cfg_err,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              acc_secure,
    output logic              acc_permit,
    output logic              acc_fault
);
    localparam int NB = 2;
    localparam int IW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

    logic [ADDR_W-1:0] bank_rd [NB];
    logic [NB-1:0]     bank_en;
    logic [NB-1:0]     bank_bg;
    logic [NB-1:0]     bank_any;
    region_t           bank_win [NB];
    logic              grant;
    blk_t              blk;

    assign grant = cfg_valid && cfg_priv;
    assign blk   = acc_addr[ADDR_W-1:GRAN_LOG2];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        rgn_mpu_bank #(.N(NUM_REGIONS), .IW(IW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (grant && cfg_write && (cfg_secure == b[0])),
            .cfg_idx (cfg_addr),
            .wr_data (cfg_wdata),
            .rd_data (bank_rd[b]),
            .blk     (blk),
            .ctl_en  (bank_en[b]),
            .ctl_bg  (bank_bg[b]),
            .any_hit (bank_any[b]),
            .win     (bank_win[b])
        );
    end

    assign cfg_err   = cfg_valid && !cfg_priv;
    assign cfg_rdata = grant ? bank_rd[cfg_secure] : '0;

    logic    sel_en;
    logic    sel_bg;
    logic    sel_any;
    region_t sel_win;
    logic    allow;

    assign sel_en  = bank_en[acc_secure];
    assign sel_bg  = bank_bg[acc_secure];
    assign sel_any = bank_any[acc_secure];
    assign sel_win = bank_win[acc_secure];

    always_comb begin
        if (!sel_en)
            allow = 1'b1;
        else if (!sel_any)
            allow = acc_priv && sel_bg;
        else if (sel_win.po && !acc_priv)
            allow = 1'b0;
        else if (sel_win.ro && acc_write)
            allow = 1'b0;
        else
            allow = 1'b1;
    end

    assign acc_permit = acc_valid && allow;
    assign acc_fault  = acc_valid && !allow;

    assert_disabled_permit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !sel_en) |-> (acc_permit && !acc_fault));
    assert_priv_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sel_en && sel_any && sel_win.po && !acc_priv) |-> acc_fault);
    assert_read_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sel_en && sel_any && sel_win.ro && acc_write) |-> acc_fault);
    assert_no_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sel_en && !sel_any) |-> (acc_permit == (acc_priv && sel_bg)));
    assert_cfg_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_priv) |-> (cfg_err && cfg_rdata == '0));
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!acc_permit && !acc_fault));
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_permit && acc_fault));
endmodule

// File: tb/tb_rgn_mpu.sv
module tb_rgn_mpu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_write = 1'b0, cfg_priv = 1'b0, cfg_secure = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0, acc_secure = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_permit, acc_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rgn_mpu dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_priv(cfg_priv),
        .cfg_secure(cfg_secure), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_secure(acc_secure),
        .acc_permit(acc_permit), .acc_fault(acc_fault)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(input bit sec, input bit priv, input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_priv = priv; cfg_secure = sec;
        cfg_addr = 5'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic cfg_rd(input bit sec, input bit priv, input int idx, output logic [31:0] d, output logic e);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_priv = priv; cfg_secure = sec; cfg_addr = 5'(idx);
        #1;
        d = cfg_rdata; e = cfg_err;
        cfg_valid = 0;
    endtask

    task automatic acc_chk(input string req, input bit sec, input bit priv, input bit wr,
                           input logic [31:0] a, input bit exp_permit);
        @(negedge clk);
        acc_valid = 1; acc_secure = sec; acc_priv = priv; acc_write = wr; acc_addr = a;
        #1;
        check(req, $sformatf("permit @%h", a), {31'd0, acc_permit}, {31'd0, exp_permit});
        check(req, $sformatf("fault @%h", a), {31'd0, acc_fault}, {31'd0, !exp_permit});
        acc_valid = 0;
    endtask

    task automatic t_reset_r1;
        logic [31:0] d; logic e;
        cfg_rd(0, 1, 0, d, e);  check("R1", "ns ctrl", d, 0);
        cfg_rd(1, 1, 0, d, e);  check("R1", "s ctrl", d, 0);
        cfg_rd(0, 1, 8, d, e);  check("R1", "ns lower0", d, 0);
        cfg_rd(1, 1, 23, d, e); check("R1", "s upper7", d, 0);
        @(negedge clk); #1;
        check("R11", "idle permit", {31'd0, acc_permit}, 0);
        check("R11", "idle fault", {31'd0, acc_fault}, 0);
    endtask

    task automatic t_disabled_r2;
        acc_chk("R2", 0, 0, 1, 32'h0000_1000, 1);
        acc_chk("R2", 1, 0, 0, 32'hFFFF_FFFC, 1);
        acc_chk("R2", 0, 1, 0, 32'h8000_0000, 1);
    endtask

    task automatic t_encoding_r10;
        logic [31:0] d; logic e;
        cfg_wr(0, 1, 10, 32'h2000_003F);
        cfg_rd(0, 1, 10, d, e); check("R10", "lower2 readback", d, 32'h2000_0021);
        cfg_wr(0, 1, 18, 32'hFFFF_FFFF);
        cfg_rd(0, 1, 18, d, e); check("R10", "upper2 readback", d, 32'hFFFF_FFE3);
        cfg_wr(0, 1, 3, 32'hFFFF_FFFF);
        cfg_rd(0, 1, 3, d, e);  check("R10", "unmapped word", d, 0);
        cfg_wr(0, 1, 10, 0);
        cfg_wr(0, 1, 18, 0);
    endtask

    task automatic t_bounds_r3;
        cfg_wr(0, 1, 0, 32'h1);
        cfg_wr(0, 1, 8, 32'h0000_1001);
        cfg_wr(0, 1, 16, 32'h0000_10E0);
        acc_chk("R3", 0, 0, 0, 32'h0000_1000, 1);
        acc_chk("R3", 0, 0, 0, 32'h0000_10FF, 1);
        acc_chk("R3", 0, 0, 0, 32'h0000_0FFF, 0);
        acc_chk("R3", 0, 0, 0, 32'h0000_1100, 0);
        cfg_wr(0, 1, 8, 32'h0000_1000);
        acc_chk("R3", 0, 0, 0, 32'h0000_1000, 0);
        cfg_wr(0, 1, 8, 32'h0000_1001);
    endtask

    task automatic t_flags_r4_r5;
        cfg_wr(0, 1, 9, 32'h0000_2001);
        cfg_wr(0, 1, 17, 32'h0000_2FE2);
        acc_chk("R4", 0, 0, 0, 32'h0000_2400, 0);
        acc_chk("R4", 0, 1, 0, 32'h0000_2400, 1);
        acc_chk("R4", 0, 1, 1, 32'h0000_2400, 1);
        cfg_wr(0, 1, 10, 32'h0000_3001);
        cfg_wr(0, 1, 18, 32'h0000_3FE1);
        acc_chk("R5", 0, 0, 1, 32'h0000_3100, 0);
        acc_chk("R5", 0, 1, 1, 32'h0000_3100, 0);
        acc_chk("R5", 0, 0, 0, 32'h0000_3100, 1);
    endtask

    task automatic t_overlap_r6;
        cfg_wr(0, 1, 11, 32'h0000_4001);
        cfg_wr(0, 1, 19, 32'h0000_4FE1);
        cfg_wr(0, 1, 13, 32'h0000_4801);
        cfg_wr(0, 1, 21, 32'h0000_48E0);
        acc_chk("R6", 0, 0, 1, 32'h0000_4800, 1);
        acc_chk("R6", 0, 0, 1, 32'h0000_4000, 0);
        cfg_wr(0, 1, 12, 32'h0000_5001);
        cfg_wr(0, 1, 20, 32'h0000_5FE0);
        cfg_wr(0, 1, 14, 32'h0000_5001);
        cfg_wr(0, 1, 22, 32'h0000_50E2);
        acc_chk("R6", 0, 0, 0, 32'h0000_5000, 0);
        acc_chk("R6", 0, 0, 0, 32'h0000_5800, 1);
    endtask

    task automatic t_background_r7;
        acc_chk("R7", 0, 1, 0, 32'h0000_9000, 0);
        acc_chk("R7", 0, 0, 0, 32'h0000_9000, 0);
        cfg_wr(0, 1, 0, 32'h3);
        acc_chk("R7", 0, 1, 1, 32'h0000_9000, 1);
        acc_chk("R7", 0, 0, 0, 32'h0000_9000, 0);
    endtask

    task automatic t_banks_r8;
        logic [31:0] d; logic e;
        acc_chk("R8", 1, 0, 0, 32'h0000_9000, 1);
        cfg_wr(1, 1, 0, 32'h1);
        acc_chk("R8", 1, 1, 0, 32'h0000_1000, 0);
        acc_chk("R8", 0, 0, 0, 32'h0000_1000, 1);
        cfg_rd(0, 1, 0, d, e); check("R8", "ns ctrl kept", d, 32'h3);
        cfg_rd(1, 1, 8, d, e); check("R8", "s lower0 empty", d, 0);
    endtask

    task automatic t_unpriv_cfg_r9;
        logic [31:0] d; logic e;
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_priv = 0; cfg_secure = 0; cfg_addr = 0; cfg_wdata = 0;
        acc_valid = 1; acc_secure = 0; acc_priv = 0; acc_write = 0; acc_addr = 32'h0000_9000;
        #1;
        check("R9", "cfg_err on unpriv write", {31'd0, cfg_err}, 1);
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
        #1;
        check("R9", "fault after refused write", {31'd0, acc_fault}, 1);
        acc_valid = 0;
        cfg_rd(0, 1, 0, d, e); check("R9", "ctrl unchanged", d, 32'h3);
        cfg_rd(0, 0, 0, d, e);
        check("R9", "unpriv read data", d, 0);
        check("R9", "unpriv read err", {31'd0, e}, 1);
        cfg_rd(0, 1, 0, d, e); check("R9", "priv read no err", {31'd0, e}, 0);
    endtask

    task automatic t_same_cycle_r11;
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_priv = 1; cfg_secure = 0; cfg_addr = 0; cfg_wdata = 0;
        acc_valid = 1; acc_secure = 0; acc_priv = 0; acc_write = 0; acc_addr = 32'h0000_9000;
        #1;
        check("R11", "verdict uses old config", {31'd0, acc_fault}, 1);
        @(negedge clk);
        cfg_valid = 0; cfg_write = 0;
        #1;
        check("R11", "verdict after write", {31'd0, acc_permit}, 1);
        acc_valid = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset_r1();
        t_disabled_r2();
        t_encoding_r10();
        t_bounds_r3();
        t_flags_r4_r5();
        t_overlap_r6();
        t_background_r7();
        t_banks_r8();
        t_unpriv_cfg_r9();
        t_same_cycle_r11();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule